// File: doc/BRIEF.md
# BCD Calendar Counter with 12/24-Hour Hour Encoding

This block keeps the time of day and the calendar date: seconds, minutes, hours, weekday, day of month, month and a two-digit year spanning 2000 to 2099. A one-cycle pulse on the seconds tick input moves the time forward by one second. The carries ripple through minutes, hours, day, month and year. The day of month wraps at the end of each month, and February has a leap day in years divisible by four.

The seven fields are always visible on output bytes in register encoding, so a serial front end can copy them into a snapshot when a transfer starts. The same front end writes single fields with a load strobe, a field index and a data byte. A mode input selects the hour encoding. It controls both how the hour is shown and how a loaded hour byte is read. The other fields are plain packed BCD.

Top module: `cal_clock`

## Requirements
- R1: After reset the outputs show seconds 00, minutes 00, hours 00 (24-hour mode), weekday 01, day 01, month 01 and year 00.
- R2: Each tick adds one second. Seconds and minutes are BCD 00 to 59, and each wraps from 59 to 00 with a carry into the next field. Minutes stay unchanged on a tick that does not wrap the seconds.
- R3: With `mode24` high the hour output is BCD 00 to 23. The hour wraps from 23 to 00 and carries into the day of month and the weekday.
- R4: With `mode24` low the hour output is {pm, 0, bcd(1..12)}, with the PM flag in bit 5. Internal hour 0 shows as 8'h12, hours 1 to 11 show as themselves, hour 12 shows as 8'h32, and hours 13 to 23 show as 8'h20 plus the BCD of hour minus 12.
- R5: With `mode24` low, a loaded hour is the BCD value of bits 4:0, plus 12 when bit 5 is set. A result of 12 is stored as hour 0 and a result of 24 as hour 12.
- R6: The load field index is 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month and 6 year. The data byte is masked before BCD decoding: 8'h7F for seconds and minutes, 8'h3F for the hour in 24-hour mode and for the day, 8'h1F for the month, and the full byte for the year. Index 7 changes nothing.
- R7: The weekday runs 1 to 7 and wraps from 7 to 1 when the day advances. A weekday load uses only data bits 2:0.
- R8: The day of month wraps to 01 after day 31 in months 1, 3, 5, 7, 8, 10 and 12, after day 30 in months 4, 6, 9 and 11, and in month 2 after day 29 when the year is divisible by 4 and after day 28 otherwise. Each wrap advances the month.
- R9: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R10: A load takes effect on the next clock edge. While the load strobe is high, a tick is ignored entirely and no field advances.
- R11: With neither a tick nor a load, every field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse, advance by one second |
| loadEn | input | 1 | Load strobe for one field |
| loadIdx | input | 3 | Index of the field to load |
| loadData | input | 8 | Byte to load, in register encoding |
| mode24 | input | 1 | 1: 24-hour hour encoding, 0: 12-hour with PM flag |
| outSec | output | 8 | Seconds, BCD |
| outMin | output | 8 | Minutes, BCD |
| outHour | output | 8 | Hours, in the encoding selected by mode24 |
| outWday | output | 8 | Weekday 1 to 7 |
| outMday | output | 8 | Day of month, BCD |
| outMonth | output | 8 | Month 01 to 12, BCD |
| outYear | output | 8 | Year 00 to 99, BCD |

## Verification
The bench builds the block with its default last-year value of 99. Any field can be loaded directly, so every rollover is one load sequence and one tick away: end of month, leap February, midnight weekday wrap and the century wrap from 99 to 00. No test needs long runs of ticks. With the default, the leap rule on the year's low two bits is exercised for both a leap year and a common year inside the single century the counter covers.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int IDX_W      = 3;
  localparam int BYTE_W     = 8;

  typedef enum logic [IDX_W-1:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_WDAY = 3'd3,
    F_MDAY = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6
  } calField_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                  advance;
    logic [NUM_FIELDS-1:0] loadSel;
  } calStrobe_t;

  // binary time fields
  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [2:0] wday;
    logic [5:0] mday;
    logic [4:0] mon;
    logic [7:0] year;
  } calTime_t;

  function automatic logic [7:0] bcdToBin(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] binToBcd(input logic [7:0] v);
    logic [7:0] t;
    logic [7:0] u;
    t = v / 8'd10;
    u = v % 8'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [5:0] daysInMonth(input logic [4:0] mon,
                                             input logic [7:0] year);
    logic [5:0] d;
    case (mon)
      5'd2:                      d = (year[1:0] == 2'b00) ? 6'd29 : 6'd28;
      5'd4, 5'd6, 5'd9, 5'd11:   d = 6'd30;
      default:                   d = 6'd31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
(
  input  logic             secTick,
  input  logic             loadEn,
  input  logic [IDX_W-1:0] loadIdx,
  output calStrobe_t       strb
);

  // a load suppresses the tick for the whole cycle
  assign strb.advance = secTick & ~loadEn;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_sel
    assign strb.loadSel[i] = loadEn && (loadIdx == IDX_W'(i));
  end

endmodule

// File: rtl/cal_dp.sv
module cal_dp
  import cal_pkg::*;
#(
  parameter int YEAR_LAST = 99
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strb,
  input  logic [BYTE_W-1:0] loadData,
  input  logic              mode24,
  output calTime_t          curTime
);

  localparam logic [6:0] SEC_LAST  = 7'd59;
  localparam logic [6:0] MIN_LAST  = 7'd59;
  localparam logic [5:0] HOUR_LAST = 6'd23;
  localparam logic [2:0] WDAY_LAST = 3'd7;
  localparam logic [4:0] MON_LAST  = 5'd12;
  localparam logic [7:0] YEAR_END  = 8'(YEAR_LAST);

  calTime_t cur;
  calTime_t nxt;

  logic [7:0] decSec, decMin, decHour24, decHour12Raw, decMday, decMon, decYear;
  logic [7:0] hour12Sum;
  logic [5:0] hourLoad;
  logic [5:0] monthDays;
  logic       secEnd, minEnd, hourEnd, dayEnd, monEnd, yearEnd;
  logic       cMin, cHour, cDay, cMon, cYear;

  // masked BCD decode of the load byte
  always_comb begin
    decSec       = bcdToBin(loadData & 8'h7F);
    decMin       = bcdToBin(loadData & 8'h7F);
    decHour24    = bcdToBin(loadData & 8'h3F);
    decHour12Raw = bcdToBin(loadData & 8'h1F);
    decMday      = bcdToBin(loadData & 8'h3F);
    decMon       = bcdToBin(loadData & 8'h1F);
    decYear      = bcdToBin(loadData);
  end

  // 12-hour load: add 12 for PM, fold 12 and 24
  always_comb begin
    hour12Sum = decHour12Raw + (loadData[5] ? 8'd12 : 8'd0);
    if (hour12Sum == 8'd12)      hour12Sum = 8'd0;
    else if (hour12Sum == 8'd24) hour12Sum = 8'd12;
    hourLoad = mode24 ? decHour24[5:0] : hour12Sum[5:0];
  end

  // carry chain
  always_comb begin
    monthDays = daysInMonth(cur.mon, cur.year);
    secEnd  = cur.sec  >= SEC_LAST;
    minEnd  = cur.min  >= MIN_LAST;
    hourEnd = cur.hour >= HOUR_LAST;
    dayEnd  = cur.mday >= monthDays;
    monEnd  = cur.mon  >= MON_LAST;
    yearEnd = cur.year >= YEAR_END;
    cMin  = strb.advance & secEnd;
    cHour = cMin  & minEnd;
    cDay  = cHour & hourEnd;
    cMon  = cDay  & dayEnd;
    cYear = cMon  & monEnd;
  end

  always_comb begin
    nxt = cur;
    if (strb.advance) nxt.sec  = secEnd  ? 7'd0 : cur.sec + 7'd1;
    if (cMin)         nxt.min  = minEnd  ? 7'd0 : cur.min + 7'd1;
    if (cHour)        nxt.hour = hourEnd ? 6'd0 : cur.hour + 6'd1;
    if (cDay) begin
      nxt.wday = (cur.wday >= WDAY_LAST || cur.wday == 3'd0) ? 3'd1 : cur.wday + 3'd1;
      nxt.mday = dayEnd ? 6'd1 : cur.mday + 6'd1;
    end
    if (cMon)         nxt.mon  = monEnd  ? 5'd1 : cur.mon + 5'd1;
    if (cYear)        nxt.year = yearEnd ? 8'd0 : cur.year + 8'd1;

    if (strb.loadSel[F_SEC])  nxt.sec  = decSec[6:0];
    if (strb.loadSel[F_MIN])  nxt.min  = decMin[6:0];
    if (strb.loadSel[F_HOUR]) nxt.hour = hourLoad;
    if (strb.loadSel[F_WDAY]) nxt.wday = loadData[2:0];
    if (strb.loadSel[F_MDAY]) nxt.mday = decMday[5:0];
    if (strb.loadSel[F_MON])  nxt.mon  = decMon[4:0];
    if (strb.loadSel[F_YEAR]) nxt.year = decYear;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur.sec  <= '0;
      cur.min  <= '0;
      cur.hour <= '0;
      cur.wday <= 3'd1;
      cur.mday <= 6'd1;
      cur.mon  <= 5'd1;
      cur.year <= '0;
    end else begin
      cur <= nxt;
    end
  end

  assign curTime = cur;

endmodule

// File: rtl/cal_fmt.sv
module cal_fmt
  import cal_pkg::*;
(
  input  calTime_t          curTime,
  input  logic              mode24,
  output logic [BYTE_W-1:0] fmtSec,
  output logic [BYTE_W-1:0] fmtMin,
  output logic [BYTE_W-1:0] fmtHour,
  output logic [BYTE_W-1:0] fmtWday,
  output logic [BYTE_W-1:0] fmtMday,
  output logic [BYTE_W-1:0] fmtMonth,
  output logic [BYTE_W-1:0] fmtYear
);

  logic [7:0] hourBin;

  always_comb begin
    hourBin  = {2'b00, curTime.hour};
    fmtSec   = binToBcd({1'b0, curTime.sec});
    fmtMin   = binToBcd({1'b0, curTime.min});
    fmtWday  = {5'd0, curTime.wday};
    fmtMday  = binToBcd({2'b00, curTime.mday});
    fmtMonth = binToBcd({3'b000, curTime.mon});
    fmtYear  = binToBcd(curTime.year);
    if (mode24)                 fmtHour = binToBcd(hourBin);
    else if (hourBin == 8'd0)   fmtHour = 8'h12;
    else if (hourBin < 8'd12)   fmtHour = binToBcd(hourBin);
    else if (hourBin == 8'd12)  fmtHour = 8'h32;
    else                        fmtHour = 8'h20 | binToBcd(hourBin - 8'd12);
  end

endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int YEAR_LAST = 99
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        secTick,
  input  logic        loadEn,
  input  logic [2:0]  loadIdx,
  input  logic [7:0]  loadData,
  input  logic        mode24,
  output logic [7:0]  outSec,
  output logic [7:0]  outMin,
  output logic [7:0]  outHour,
  output logic [7:0]  outWday,
  output logic [7:0]  outMday,
  output logic [7:0]  outMonth,
  output logic [7:0]  outYear
);

  calStrobe_t strb;
  calTime_t   curTime;

  cal_ctrl u_ctrl (
    .secTick (secTick),
    .loadEn  (loadEn),
    .loadIdx (loadIdx),
    .strb    (strb)
  );

  cal_dp #(.YEAR_LAST(YEAR_LAST)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .loadData (loadData),
    .mode24   (mode24),
    .curTime  (curTime)
  );

  cal_fmt u_fmt (
    .curTime  (curTime),
    .mode24   (mode24),
    .fmtSec   (outSec),
    .fmtMin   (outMin),
    .fmtHour  (outHour),
    .fmtWday  (outWday),
    .fmtMday  (outMday),
    .fmtMonth (outMonth),
    .fmtYear  (outYear)
  );

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk (
  input logic       clk,
  input logic       rstN,
  input logic       secTick,
  input logic       loadEn,
  input logic [2:0] loadIdx,
  input logic [7:0] loadData,
  input logic       mode24,
  input logic [7:0] outSec,
  input logic [7:0] outMin,
  input logic [7:0] outHour,
  input logic [7:0] outWday,
  input logic [7:0] outMday,
  input logic [7:0] outMonth,
  input logic [7:0] outYear
);

  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= rstN;

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    secTick && !loadEn && outSec == 8'h59 |=> outSec == 8'h00);

  p_min_hold_r2: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    secTick && !loadEn && outSec < 8'h59 |=> $stable(outMin));

  p_hour12_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    !mode24 |-> outHour != 8'h00);

  p_wday_wrap_r7: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    secTick && !loadEn && mode24 && outSec == 8'h59 && outMin == 8'h59 &&
    outHour == 8'h23 && outWday == 8'h07 |=> outWday == 8'h01);

  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    loadEn && loadIdx == 3'd0 && loadData[3:0] <= 4'd9 && loadData[6:4] <= 3'd5
    |=> outSec == ($past(loadData) & 8'h7F));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    !secTick && !loadEn |=> $stable(outSec) && $stable(outMin) && $stable(outWday) &&
    $stable(outMday) && $stable(outMonth) && $stable(outYear) &&
    (!$stable(mode24) || $stable(outHour)));

endmodule

bind cal_clock cal_clock_chk u_chk (.*);

// File: tb/cal_clock_test.sv
module cal_clock_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic       loadEn = 1'b0;
  logic [2:0] loadIdx = 3'd0;
  logic [7:0] loadData = 8'h00;
  logic       mode24 = 1'b1;
  logic [7:0] outSec, outMin, outHour, outWday, outMday, outMonth, outYear;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  cal_clock uut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .loadEn(loadEn),
    .loadIdx(loadIdx), .loadData(loadData), .mode24(mode24),
    .outSec(outSec), .outMin(outMin), .outHour(outHour), .outWday(outWday),
    .outMday(outMday), .outMonth(outMonth), .outYear(outYear)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] idx, input logic [7:0] data);
    @(negedge clk);
    loadEn = 1'b1; loadIdx = idx; loadData = data;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic loadTick(input logic [2:0] idx, input logic [7:0] data);
    @(negedge clk);
    loadEn = 1'b1; secTick = 1'b1; loadIdx = idx; loadData = data;
    @(negedge clk);
    loadEn = 1'b0; secTick = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic setTime(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                         input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
    mode24 = 1'b1;
    load(3'd6, y); load(3'd5, mo); load(3'd4, d);
    load(3'd2, h); load(3'd1, mi); load(3'd0, s);
  endtask

  task automatic testReset();
    chk("R1 sec", outSec, 8'h00);   chk("R1 min", outMin, 8'h00);
    chk("R1 hour", outHour, 8'h00); chk("R1 wday", outWday, 8'h01);
    chk("R1 mday", outMday, 8'h01); chk("R1 month", outMonth, 8'h01);
    chk("R1 year", outYear, 8'h00);
  endtask

  task automatic testSeconds();
    load(3'd0, 8'h58);
    tick();
    chk("R2 sec 59", outSec, 8'h59); chk("R2 min held", outMin, 8'h00);
    tick();
    chk("R2 sec wrap", outSec, 8'h00); chk("R2 min carry", outMin, 8'h01);
    load(3'd1, 8'h59); load(3'd0, 8'h59);
    tick();
    chk("R2 min wrap", outMin, 8'h00); chk("R2 hour carry", outHour, 8'h01);
  endtask

  task automatic testMidnight();
    mode24 = 1'b1;
    load(3'd2, 8'h13);
    chk("R3 hour 13", outHour, 8'h13);
    setTime(8'h24, 8'h03, 8'h10, 8'h23, 8'h59, 8'h59);
    load(3'd3, 8'h03);
    tick();
    chk("R3 hour wrap", outHour, 8'h00); chk("R3 mday carry", outMday, 8'h11);
    chk("R3 wday carry", outWday, 8'h04); chk("R3 month held", outMonth, 8'h03);
  endtask

  task automatic show12(input logic [7:0] h24, input logic [7:0] exp);
    mode24 = 1'b1;
    load(3'd2, h24);
    mode24 = 1'b0;
    #1;
    chk("R4 12h out", outHour, exp);
    mode24 = 1'b1;
  endtask

  task automatic test12Out();
    show12(8'h00, 8'h12); show12(8'h11, 8'h11); show12(8'h12, 8'h32);
    show12(8'h13, 8'h21); show12(8'h23, 8'h31);
  endtask

  task automatic load12(input logic [7:0] d, input logic [7:0] exp24);
    mode24 = 1'b0;
    load(3'd2, d);
    mode24 = 1'b1;
    #1;
    chk("R5 12h load", outHour, exp24);
  endtask

  task automatic test12Load();
    load12(8'h12, 8'h00); load12(8'h32, 8'h12); load12(8'h27, 8'h19);
    load12(8'h07, 8'h07); load12(8'h31, 8'h23);
  endtask

  task automatic testMasks();
    logic [7:0] snap [7];
    mode24 = 1'b1;
    load(3'd0, 8'hD5); chk("R6 sec mask", outSec, 8'h55);
    load(3'd1, 8'h83); chk("R6 min mask", outMin, 8'h03);
    load(3'd2, 8'hC9); chk("R6 hour mask", outHour, 8'h09);
    load(3'd4, 8'hE5); chk("R6 mday mask", outMday, 8'h25);
    load(3'd5, 8'hE9); chk("R6 month mask", outMonth, 8'h09);
    load(3'd6, 8'h87); chk("R6 year full", outYear, 8'h87);
    snap[0] = outSec; snap[1] = outMin; snap[2] = outHour; snap[3] = outWday;
    snap[4] = outMday; snap[5] = outMonth; snap[6] = outYear;
    load(3'd7, 8'h42);
    chk("R6 idx7 sec", outSec, snap[0]);   chk("R6 idx7 min", outMin, snap[1]);
    chk("R6 idx7 hour", outHour, snap[2]); chk("R6 idx7 wday", outWday, snap[3]);
    chk("R6 idx7 mday", outMday, snap[4]); chk("R6 idx7 month", outMonth, snap[5]);
    chk("R6 idx7 year", outYear, snap[6]);
  endtask

  task automatic testWday();
    load(3'd3, 8'hFB);
    chk("R7 wday bits", outWday, 8'h03);
    setTime(8'h10, 8'h05, 8'h05, 8'h23, 8'h59, 8'h59);
    load(3'd3, 8'h07);
    tick();
    chk("R7 wday wrap", outWday, 8'h01);
  endtask

  task automatic endOfDay(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                          input logic [7:0] expD, input logic [7:0] expMo);
    setTime(y, mo, d, 8'h23, 8'h59, 8'h59);
    tick();
    chk("R8 mday", outMday, expD);
    chk("R8 month", outMonth, expMo);
  endtask

  task automatic testMonths();
    endOfDay(8'h23, 8'h02, 8'h28, 8'h01, 8'h03);
    endOfDay(8'h24, 8'h02, 8'h28, 8'h29, 8'h02);
    tick();
    endOfDay(8'h24, 8'h02, 8'h29, 8'h01, 8'h03);
    endOfDay(8'h24, 8'h04, 8'h30, 8'h01, 8'h05);
    endOfDay(8'h24, 8'h01, 8'h30, 8'h31, 8'h01);
    endOfDay(8'h24, 8'h01, 8'h31, 8'h01, 8'h02);
  endtask

  task automatic testYear();
    setTime(8'h45, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    tick();
    chk("R9 month wrap", outMonth, 8'h01); chk("R9 year carry", outYear, 8'h46);
    setTime(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    tick();
    chk("R9 century mday", outMday, 8'h01); chk("R9 century month", outMonth, 8'h01);
    chk("R9 century year", outYear, 8'h00);
  endtask

  task automatic testLoadTick();
    setTime(8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h10);
    loadTick(3'd0, 8'h30);
    chk("R10 sec loaded", outSec, 8'h30); chk("R10 min kept", outMin, 8'h09);
    loadTick(3'd1, 8'h44);
    chk("R10 min loaded", outMin, 8'h44); chk("R10 sec not ticked", outSec, 8'h30);
  endtask

  task automatic testHold();
    setTime(8'h33, 8'h07, 8'h15, 8'h12, 8'h34, 8'h56);
    repeat (5) @(negedge clk);
    chk("R11 sec", outSec, 8'h56);    chk("R11 min", outMin, 8'h34);
    chk("R11 hour", outHour, 8'h12);  chk("R11 mday", outMday, 8'h15);
    chk("R11 month", outMonth, 8'h07); chk("R11 year", outYear, 8'h33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSeconds();
    testMidnight();
    test12Out();
    test12Load();
    testMasks();
    testWday();
    testMonths();
    testYear();
    testLoadTick();
    testHold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule